// File: doc/BRIEF.md
# Ring Scrubber Orphan-Packet Remover

This block is a pass-through stage on a ring node. Exactly one node on a ring has its stage enabled as the scrubber, and that choice is fixed when the ring is brought up. The enable arrives on a strap input. The stage takes a stream of symbols, each with a flag bit, and finds packet boundaries from that flag. On every packet that goes past, it sets a circulation mark in the header symbol.

A packet that comes back with the mark already set has gone once round the ring and no node has taken it. If its destination field also names a node that the valid-destination table does not hold, the stage removes the packet completely. Idle symbols take the place of every symbol of that packet, and a saturating counter adds one. The header changes when the mark is set, so the trailing check symbol of each forwarded packet is computed again.

When the strap is low, the stage is a plain one-cycle register on the stream.

Top module: `ring_scrubber`

## Requirements
- R1: With `scrub_en_i` low, `sym_o`/`flag_o` equal `sym_i`/`flag_i` of the previous cycle, bit for bit, for every symbol, marked or not. The drop counter does not change.
- R2: A packet starts on the symbol where `flag_i` goes from 0 to 1 (the header). `flag_i` stays 1 through the body. The final TAIL_LEN symbols (default 4) carry `flag_i` = 0, and the last of them is the check symbol. A new header may follow the check symbol directly.
- R3: With the stage enabled, a forwarded header leaves one cycle later with bit MARK_BIT (default 15) set and all its other bits unchanged. Body and tail symbols other than the check symbol leave unchanged, one cycle later, with their flag.
- R4: A header whose mark bit is 0 is never dropped, whatever its destination.
- R5: With the stage enabled, a header with the mark bit set whose destination field (bits [DEST_W-1:0], default [5:0]) indexes a 0 in `dest_valid_i` causes a drop. Every symbol of that packet, header through check symbol, leaves as IDLE_SYM (default 16'h0000) with flag 0.
- R6: A marked header whose destination indexes a 1 in `dest_valid_i` is forwarded like any other packet.
- R7: With the stage enabled, the check symbol of a forwarded packet is replaced by a CRC over the forwarded symbols from the header up to the symbol before the check symbol. The CRC is CRC-16, polynomial 0x1021, initial value 0xFFFF, MSB first, with no final inversion. The incoming check symbol is not used.
- R8: `drop_cnt_o` is 0 after reset. It adds one for each dropped packet and holds at 2^CNT_W-1.
- R9: With the stage enabled, symbols outside any packet leave unchanged, one cycle later, with flag 0.
- R10: During reset, `sym_o`, `flag_o` and `drop_cnt_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scrub_en_i | input | 1 | Strap that makes this node the scrubber |
| sym_i | input | SYM_W | Incoming symbol |
| flag_i | input | 1 | Incoming framing flag |
| dest_valid_i | input | 2**DEST_W | One bit per node id; 1 marks a valid destination |
| sym_o | output | SYM_W | Outgoing symbol |
| flag_o | output | 1 | Outgoing framing flag |
| drop_cnt_o | output | CNT_W | Saturating count of removed packets |

## Verification
If the framer's phase goes wrong, it shows one cycle after the symbol concerned. A header is treated as body and left unmarked, or the check symbol lands on the wrong position and overwrites a payload or tail symbol. A stale drop decision blanks a packet that should have passed, or lets a dropped packet's tail through, and the counter moves by the wrong amount at the next header. A wrong running CRC appears only at the check symbol, TAIL_LEN symbols after the flag falls. So each directed packet is compared symbol by symbol on every cycle, with the check value computed independently, and the streams include back-to-back packets and a header-plus-tail packet.

// File: rtl/ring_scrub_pkg.sv
package ring_scrub_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_BODY = 2'd1,
      PH_TAIL = 2'd2
   } scrub_phase_e;
endpackage

// File: rtl/ring_scrub_framer.sv
module ring_scrub_framer
   import ring_scrub_pkg::*;
#(
   parameter int TAIL_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   output logic hdr_o,
   output logic chk_o,
   output logic pkt_o
);
   localparam int TW = $clog2(TAIL_LEN + 1);
   localparam logic [TW-1:0] LAST_IDX = TW'(TAIL_LEN - 1);

   scrub_phase_e ph_q, ph_d;
   logic [TW-1:0] tcnt_q, tcnt_d;

   always_comb begin
      ph_d   = ph_q;
      tcnt_d = tcnt_q;
      hdr_o  = 1'b0;
      chk_o  = 1'b0;
      pkt_o  = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (flag_i) begin
               hdr_o = 1'b1;
               pkt_o = 1'b1;
               ph_d  = PH_BODY;
            end
         end
         PH_BODY: begin
            pkt_o = 1'b1;
            if (!flag_i) begin
               if (TAIL_LEN == 1) begin
                  chk_o = 1'b1;
                  ph_d  = PH_IDLE;
               end else begin
                  ph_d   = PH_TAIL;
                  tcnt_d = TW'(1);
               end
            end
         end
         PH_TAIL: begin
            pkt_o = 1'b1;
            if (tcnt_q == LAST_IDX) begin
               chk_o = 1'b1;
               ph_d  = PH_IDLE;
            end else begin
               tcnt_d = tcnt_q + TW'(1);
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         tcnt_q <= '0;
      end else begin
         ph_q   <= ph_d;
         tcnt_q <= tcnt_d;
      end
   end
endmodule

// File: rtl/ring_scrub_crc.sv
module ring_scrub_crc #(
   parameter int              W    = 16,
   parameter logic [W-1:0]    POLY = 16'h1021,
   parameter logic [W-1:0]    SEED = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         adv_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] crc_o
);
   logic [W-1:0] crc_q;
   logic [W-1:0] chain [0:W];

   assign chain[0] = start_i ? SEED : crc_q;

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic fb;
      assign fb         = chain[b][W-1] ^ din_i[W-1-b];
      assign chain[b+1] = {chain[b][W-2:0], 1'b0} ^ ({W{fb}} & POLY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= SEED;
      else if (adv_i) crc_q <= chain[W];
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/ring_scrub_sat_cnt.sv
module ring_scrub_sat_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] TOP = '1;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/ring_scrubber.sv
module ring_scrubber #(
   parameter int                 SYM_W    = 16,
   parameter int                 DEST_W   = 6,
   parameter int                 MARK_BIT = 15,
   parameter int                 TAIL_LEN = 4,
   parameter int                 CNT_W    = 8,
   parameter logic [SYM_W-1:0]   IDLE_SYM = '0,
   parameter logic [SYM_W-1:0]   CRC_POLY = 16'h1021,
   parameter logic [SYM_W-1:0]   CRC_SEED = 16'hFFFF
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scrub_en_i,
   input  logic [SYM_W-1:0]       sym_i,
   input  logic                   flag_i,
   input  logic [(1<<DEST_W)-1:0] dest_valid_i,
   output logic [SYM_W-1:0]       sym_o,
   output logic                   flag_o,
   output logic [CNT_W-1:0]       drop_cnt_o
);
   localparam logic [SYM_W-1:0] MARK_MASK = SYM_W'(1) << MARK_BIT;

   if (MARK_BIT >= SYM_W || MARK_BIT < DEST_W) begin : g_bad_mark
      $error("ring_scrubber: MARK_BIT must sit above the destination field and inside the symbol");
   end
   if (TAIL_LEN < 1) begin : g_bad_tail
      $error("ring_scrubber: TAIL_LEN must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("ring_scrubber: CNT_W must be at least 1");
   end

   logic hdr, chk_pos, in_pkt;
   logic drop_now, drop_q, cur_drop;
   logic [SYM_W-1:0] sym_mod, crc_val;

   ring_scrub_framer #(.TAIL_LEN(TAIL_LEN)) u_frm (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (flag_i),
      .hdr_o  (hdr),
      .chk_o  (chk_pos),
      .pkt_o  (in_pkt)
   );

   assign drop_now = scrub_en_i && hdr && sym_i[MARK_BIT]
                     && !dest_valid_i[sym_i[DEST_W-1:0]];
   assign cur_drop = hdr ? drop_now : drop_q;
   assign sym_mod  = hdr ? (sym_i | MARK_MASK) : sym_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   drop_q <= 1'b0;
      else if (hdr) drop_q <= drop_now;
   end

   ring_scrub_crc #(.W(SYM_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (hdr),
      .adv_i   (in_pkt && !chk_pos),
      .din_i   (sym_mod),
      .crc_o   (crc_val)
   );

   ring_scrub_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (drop_now),
      .cnt_o (drop_cnt_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_o  <= '0;
         flag_o <= 1'b0;
      end else if (!scrub_en_i) begin
         sym_o  <= sym_i;
         flag_o <= flag_i;
      end else if (in_pkt && cur_drop) begin
         sym_o  <= IDLE_SYM;
         flag_o <= 1'b0;
      end else if (chk_pos) begin
         sym_o  <= crc_val;
         flag_o <= flag_i;
      end else begin
         sym_o  <= sym_mod;
         flag_o <= flag_i;
      end
   end
endmodule

// File: rtl/ring_scrubber_chk.sv
module ring_scrubber_chk #(
   parameter int               SYM_W    = 16,
   parameter int               DEST_W   = 6,
   parameter int               MARK_BIT = 15,
   parameter int               CNT_W    = 8,
   parameter logic [SYM_W-1:0] IDLE_SYM = '0
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   en,
   input logic [SYM_W-1:0]       sym_i,
   input logic                   flag_i,
   input logic [(1<<DEST_W)-1:0] dest_valid,
   input logic                   hdr,
   input logic [SYM_W-1:0]       sym_o,
   input logic                   flag_o,
   input logic [CNT_W-1:0]       cnt
);
   localparam logic [SYM_W-1:0] MASK = SYM_W'(1) << MARK_BIT;

   a_r1_bypass_exact: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (sym_o == $past(sym_i) && flag_o == $past(flag_i)));

   a_r4_first_pass_marked: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hdr && !sym_i[MARK_BIT]) |=> (flag_o && sym_o == ($past(sym_i) | MASK)));

   a_r5_orphan_blanked: assert property (@(posedge clk) disable iff (!rst_n)
      (en && hdr && sym_i[MARK_BIT] && !dest_valid[sym_i[DEST_W-1:0]])
      |=> (!flag_o && sym_o == IDLE_SYM));

   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

   a_r8_no_count_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == $past(cnt)));
endmodule

bind ring_scrubber ring_scrubber_chk #(
   .SYM_W(SYM_W), .DEST_W(DEST_W), .MARK_BIT(MARK_BIT),
   .CNT_W(CNT_W), .IDLE_SYM(IDLE_SYM)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (scrub_en_i),
   .sym_i      (sym_i),
   .flag_i     (flag_i),
   .dest_valid (dest_valid_i),
   .hdr        (hdr),
   .sym_o      (sym_o),
   .flag_o     (flag_o),
   .cnt        (drop_cnt_o)
);

// File: tb/ring_scrubber_test.sv
`timescale 1ns/1ps
module ring_scrubber_test;
   localparam int TL = 4;
   localparam int CW = 3;
   localparam logic [15:0] IDLE = 16'h0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [15:0] sym_i = '0;
   logic        flag_i = 1'b0;
   logic [63:0] valid = 64'hFFFF_FFFF_FFFF_FDFF;   // node 9 invalid
   logic [15:0] sym_o;
   logic        flag_o;
   logic [CW-1:0] cnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] s_sym [0:63];
   logic        s_flg [0:63];
   logic [15:0] e_sym [0:63];
   logic        e_flg [0:63];
   int          s_n = 0;

   always #5 clk = ~clk;

   ring_scrubber #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .scrub_en_i(en), .sym_i(sym_i), .flag_i(flag_i),
      .dest_valid_i(valid), .sym_o(sym_o), .flag_o(flag_o), .drop_cnt_o(cnt)
   );

   task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [15:0] d);
      logic [15:0] r = c;
      for (int b = 15; b >= 0; b--) begin
         logic t = r[15] ^ d[b];
         r = {r[14:0], 1'b0};
         if (t) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   task automatic append_pkt(input logic [15:0] hdr, input int nbody);
      int total = 1 + nbody + TL;
      bit drop = en && hdr[15] && !valid[hdr[5:0]];
      logic [15:0] c = 16'hFFFF;
      for (int j = 0; j < total; j++) begin
         logic [15:0] v;
         logic f;
         if (j == 0) v = hdr;
         else if (j == total - 1) v = 16'hBEEF;
         else v = hdr ^ (16'h0313 * 16'(j));
         f = (j < total - TL);
         s_sym[s_n] = v;
         s_flg[s_n] = f;
         if (drop) begin
            e_sym[s_n] = IDLE; e_flg[s_n] = 1'b0;
         end else if (!en) begin
            e_sym[s_n] = v; e_flg[s_n] = f;
         end else begin
            if (j == 0) e_sym[s_n] = v | 16'h8000;
            else if (j == total - 1) e_sym[s_n] = c;
            else e_sym[s_n] = v;
            e_flg[s_n] = f;
            if (j < total - 1) c = crc_add(c, e_sym[s_n]);
         end
         s_n++;
      end
   endtask

   task automatic append_idle(input logic [15:0] v);
      s_sym[s_n] = v; s_flg[s_n] = 1'b0;
      e_sym[s_n] = v; e_flg[s_n] = 1'b0;
      s_n++;
   endtask

   task automatic play(input string req);
      for (int i = 0; i <= s_n; i++) begin
         @(negedge clk);
         if (i > 0) begin
            check(req, sym_o == e_sym[i-1], 32'(sym_o), 32'(e_sym[i-1]));
            check(req, flag_o == e_flg[i-1], 32'(flag_o), 32'(e_flg[i-1]));
         end
         if (i < s_n) begin
            sym_i = s_sym[i]; flag_i = s_flg[i];
         end else begin
            sym_i = IDLE; flag_i = 1'b0;
         end
      end
      s_n = 0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R10 sym", sym_o == 16'h0, 32'(sym_o), 0);
      check("R10 flag", flag_o == 1'b0, 32'(flag_o), 0);
      check("R10/R8 count", cnt == '0, 32'(cnt), 0);
   endtask

   task automatic t_bypass;   // R1: marked orphan passes untouched when disabled
      en = 1'b0;
      append_idle(16'h5A5A);
      append_pkt(16'h8009, 3);
      play("R1 bypass");
      check("R1 count", cnt == 3'd0, 32'(cnt), 0);
   endtask

   task automatic t_first_pass;   // R3 R4 R7
      en = 1'b1;
      append_pkt(16'h0009, 2);
      play("R3/R4/R7 first pass");
      check("R4 count", cnt == 3'd0, 32'(cnt), 0);
   endtask

   task automatic t_marked_valid;   // R6 R7
      append_pkt(16'h8005, 3);
      play("R6/R7 marked valid");
      check("R6 count", cnt == 3'd0, 32'(cnt), 0);
   endtask

   task automatic t_drop;   // R5 R8
      append_pkt(16'h8009, 2);
      play("R5 drop");
      check("R8 count after drop", cnt == 3'd1, 32'(cnt), 1);
   endtask

   task automatic t_min_len;   // R2: header followed directly by tail
      append_pkt(16'h0025, 0);
      play("R2 minimum packet");
   endtask

   task automatic t_back_to_back;   // R2 R5
      append_pkt(16'hC009, 1);
      append_pkt(16'h0105, 2);
      append_pkt(16'h8005, 0);
      play("R2/R5 back to back");
      check("R8 count b2b", cnt == 3'd2, 32'(cnt), 2);
   endtask

   task automatic t_idle;   // R9
      append_idle(16'h1234);
      append_idle(16'h00FF);
      append_idle(16'h8009);
      play("R9 idle pass");
   endtask

   task automatic t_saturate;   // R8
      for (int k = 0; k < 8; k++) append_pkt(16'h8009, 1);
      play("R8 saturate stream");
      check("R8 saturated", cnt == 3'd7, 32'(cnt), 7);
   endtask

   initial begin
      t_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_bypass();
      t_first_pass();
      t_marked_valid();
      t_drop();
      t_min_len();
      t_back_to_back();
      t_idle();
      t_saturate();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule